// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor

This block guesses whether a conditional branch will be taken, and it learns from what each branch actually did. It holds a table of two-bit saturating counters. The branch address selects one counter. Instructions sit on halfword boundaries, so address bit 0 never selects a counter, and the next few address bits do. When a branch is presented, the prediction comes out in the same cycle. The counter for that entry then moves towards the resolved direction on the closing clock edge.

Once the branch is resolved, the block reports three things one cycle later: whether the guess was wrong, how many stall cycles that costs (a fixed two), and a jump marker when the branch was taken. The hazard-tracking logic downstream uses the jump marker to know that control flow has just moved. Entries alias freely: address bits above the index field are not compared, so every branch that shares the index bits shares one counter.

Top module: `brpred_core`

## Requirements
- R1: Reset is synchronous and active high. It clears every counter to 0 and clears all registered outputs, so every lookup right after reset predicts not-taken.
- R2: The counter used is entry (br_pc & (TABLE_SPAN-1)) >> 1, which is address bits [log2(TABLE_SPAN)-1:1]. Bit 0 and the bits above the field never pick a different entry.
- R3: pred_taken is combinational. It equals bit 1 of the counter selected by br_pc in the same cycle, so 1 means taken (counter value 2 or 3).
- R4: On the edge that samples br_valid=1, mispredict is registered as 1 if br_taken differs from pred_taken and 0 otherwise. stall_cycles is registered as 2 when mispredict is 1, and 0 when it is 0.
- R5: A valid taken branch increments its counter, which saturates at 3.
- R6: A valid not-taken branch decrements its counter, which saturates at 0.
- R7: jump_mark is registered as 1 one cycle after a valid taken branch, and as 0 after a valid not-taken branch.
- R8: A cycle with br_valid=0 changes no counter, whatever br_pc and br_taken are. On the next cycle it gives mispredict=0, jump_mark=0 and stall_cycles=0.
- R9: An update is visible to a lookup of the same entry in the very next cycle, so back-to-back branches to one entry see each other's training.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | A resolved conditional branch is presented this cycle |
| br_pc | input | PC_W | Branch instruction address |
| br_taken | input | 1 | Resolved direction, 1 = taken |
| pred_taken | output | 1 | Predicted direction for br_pc, combinational |
| mispredict | output | 1 | Registered: the previous valid branch was mispredicted |
| jump_mark | output | 1 | Registered: the previous valid branch was taken |
| stall_cycles | output | STALL_W | Registered stall cost of the previous branch (2 or 0) |

## Verification
A corrupted counter first shows at pred_taken on the next lookup of that entry. One cycle later it also shows at mispredict and stall_cycles, because the wrong guess is scored against the resolved direction. A wrong index, for example one that uses bit 0 or skips the aliasing, shows when two addresses that must share an entry give different predictions. A lost or stray update shows when a prediction does not flip after the counted number of same-direction branches. The bench keeps a behavioural copy of every counter and compares the prediction and the registered outputs on every clock, so any such fault surfaces within one or two cycles of the entry being touched again.

// File: rtl/brp_pkg.sv
package brp_pkg;

  typedef logic [1:0] sat_ctr_t;

  localparam sat_ctr_t CTR_FLOOR = 2'd0;
  localparam sat_ctr_t CTR_CEIL  = 2'd3;

  // Move a counter one step towards the resolved direction, saturating.
  function automatic sat_ctr_t ctr_step(input sat_ctr_t cur, input logic up);
    sat_ctr_t nxt;
    if (up) begin
      nxt = (cur == CTR_CEIL) ? cur : cur + 2'd1;
    end else begin
      nxt = (cur == CTR_FLOOR) ? cur : cur - 2'd1;
    end
    return nxt;
  endfunction

  // Taken when the upper counter bit is set.
  function automatic logic ctr_says_taken(input sat_ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/brp_index.sv
module brp_index #(
  parameter int PC_W       = 32,
  parameter int TABLE_SPAN = 64,
  localparam int IDX_W     = $clog2(TABLE_SPAN) - 1
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);

  localparam logic [PC_W-1:0] SPAN_MASK = PC_W'(TABLE_SPAN - 1);

  // Halfword-aligned code: drop bit 0 after masking to the table span.
  always_comb begin
    idx = IDX_W'((pc & SPAN_MASK) >> 1);
  end

endmodule

// File: rtl/brp_table.sv
module brp_table
  import brp_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] sel_idx,
  input  logic             upd_en,
  input  logic             upd_up,
  output sat_ctr_t         sel_ctr
);

  sat_ctr_t cells [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cell
    logic hit;
    assign hit = upd_en && (sel_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (rst) begin
        cells[e] <= CTR_FLOOR;
      end else if (hit) begin
        cells[e] <= ctr_step(cells[e], upd_up);
      end
    end
  end

  always_comb begin
    sel_ctr = cells[sel_idx];
  end

endmodule

// File: rtl/brp_resolve.sv
module brp_resolve #(
  parameter int STALL_W      = 2,
  parameter int MISS_PENALTY = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               valid,
  input  logic               guess,
  input  logic               actual,
  output logic               miss_q,
  output logic               jump_q,
  output logic [STALL_W-1:0] stall_q
);

  localparam logic [STALL_W-1:0] COST = STALL_W'(MISS_PENALTY);

  logic miss_d;

  always_comb begin
    miss_d = valid && (guess != actual);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      miss_q  <= 1'b0;
      jump_q  <= 1'b0;
      stall_q <= '0;
    end else begin
      miss_q  <= miss_d;
      jump_q  <= valid && actual;
      stall_q <= miss_d ? COST : '0;
    end
  end

endmodule

// File: rtl/brpred_core.sv
module brpred_core
  import brp_pkg::*;
#(
  parameter int PC_W         = 32,
  parameter int TABLE_SPAN   = 64,
  parameter int STALL_W      = 2,
  parameter int MISS_PENALTY = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               br_valid,
  input  logic [PC_W-1:0]    br_pc,
  input  logic               br_taken,
  output logic               pred_taken,
  output logic               mispredict,
  output logic               jump_mark,
  output logic [STALL_W-1:0] stall_cycles
);

  localparam int ENTRIES = TABLE_SPAN / 2;
  localparam int IDX_W   = $clog2(TABLE_SPAN) - 1;

  logic [IDX_W-1:0] entry_idx;
  sat_ctr_t         entry_ctr;

  brp_index #(
    .PC_W       (PC_W),
    .TABLE_SPAN (TABLE_SPAN)
  ) u_index (
    .pc  (br_pc),
    .idx (entry_idx)
  );

  brp_table #(
    .ENTRIES (ENTRIES)
  ) u_table (
    .clk     (clk),
    .rst     (rst),
    .sel_idx (entry_idx),
    .upd_en  (br_valid),
    .upd_up  (br_taken),
    .sel_ctr (entry_ctr)
  );

  always_comb begin
    pred_taken = ctr_says_taken(entry_ctr);
  end

  brp_resolve #(
    .STALL_W      (STALL_W),
    .MISS_PENALTY (MISS_PENALTY)
  ) u_resolve (
    .clk     (clk),
    .rst     (rst),
    .valid   (br_valid),
    .guess   (pred_taken),
    .actual  (br_taken),
    .miss_q  (mispredict),
    .jump_q  (jump_mark),
    .stall_q (stall_cycles)
  );

endmodule

// File: rtl/brp_checker.sv
module brp_checker #(
  parameter int PC_W         = 32,
  parameter int TABLE_SPAN   = 64,
  parameter int STALL_W      = 2,
  parameter int MISS_PENALTY = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               br_valid,
  input logic [PC_W-1:0]    br_pc,
  input logic               br_taken,
  input logic               pred_taken,
  input logic               mispredict,
  input logic               jump_mark,
  input logic [STALL_W-1:0] stall_cycles
);

  localparam int IDX_W = $clog2(TABLE_SPAN) - 1;
  localparam logic [PC_W-1:0] SPAN_MASK = PC_W'(TABLE_SPAN - 1);

  logic [IDX_W-1:0] ent;
  assign ent = IDX_W'((br_pc & SPAN_MASK) >> 1);

  AST_RESET_COLD: assert property (@(posedge clk)
    rst |=> !pred_taken); // R1

  AST_MISS_FLAG: assert property (@(posedge clk) disable iff (rst)
    br_valid && (pred_taken != br_taken) |=> mispredict && (stall_cycles == STALL_W'(MISS_PENALTY))); // R4

  AST_HIT_FREE: assert property (@(posedge clk) disable iff (rst)
    br_valid && (pred_taken == br_taken) |=> !mispredict && (stall_cycles == '0)); // R4

  AST_STRONG_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(br_valid && br_taken && pred_taken) && br_valid && (ent == $past(ent)) |-> pred_taken); // R5

  AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (rst)
    br_valid && br_taken |=> jump_mark); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !br_valid |=> !mispredict && !jump_mark && (stall_cycles == '0)); // R8

endmodule

bind brpred_core brp_checker #(
  .PC_W         (PC_W),
  .TABLE_SPAN   (TABLE_SPAN),
  .STALL_W      (STALL_W),
  .MISS_PENALTY (MISS_PENALTY)
) u_brp_checker (
  .clk          (clk),
  .rst          (rst),
  .br_valid     (br_valid),
  .br_pc        (br_pc),
  .br_taken     (br_taken),
  .pred_taken   (pred_taken),
  .mispredict   (mispredict),
  .jump_mark    (jump_mark),
  .stall_cycles (stall_cycles)
);

// File: tb/brpred_core_bench.sv
`timescale 1ns/1ps
module brpred_core_bench;

  localparam int PC_W       = 32;
  localparam int SPAN       = 64;
  localparam int STALL_W    = 2;
  localparam int ENTRIES    = SPAN / 2;
  localparam int MAX_CYCLES = 200000;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               br_valid = 1'b0;
  logic [PC_W-1:0]    br_pc = '0;
  logic               br_taken = 1'b0;
  logic               pred_taken;
  logic               mispredict;
  logic               jump_mark;
  logic [STALL_W-1:0] stall_cycles;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int model [ENTRIES];
  int exp_mis = 0, exp_jmp = 0, exp_stall = 0;

  always #2 clk = ~clk;

  brpred_core #(
    .PC_W (PC_W), .TABLE_SPAN (SPAN), .STALL_W (STALL_W), .MISS_PENALTY (2)
  ) u_brpred_core (
    .clk (clk), .rst (rst), .br_valid (br_valid), .br_pc (br_pc),
    .br_taken (br_taken), .pred_taken (pred_taken), .mispredict (mispredict),
    .jump_mark (jump_mark), .stall_cycles (stall_cycles)
  );

  function automatic int ent_of(input logic [PC_W-1:0] pc);
    return int'((pc & PC_W'(SPAN - 1)) >> 1);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: at the falling edge, score last cycle's registered outputs,
  // drive the new branch, check the prediction, then advance the model.
  task automatic step(input string tag, input bit v, input logic [PC_W-1:0] pc, input bit tk);
    int e, p;
    @(negedge clk);
    check("R4 mispredict", int'(mispredict), exp_mis);
    check("R4 stall_cycles", int'(stall_cycles), exp_stall);
    check("R7 jump_mark", int'(jump_mark), exp_jmp);
    br_valid = v; br_pc = pc; br_taken = tk;
    #1;
    e = ent_of(pc);
    p = (model[e] >= 2) ? 1 : 0;
    check(tag, int'(pred_taken), p);
    if (v) begin
      exp_mis   = (p != int'(tk)) ? 1 : 0;
      exp_stall = exp_mis ? 2 : 0;
      exp_jmp   = int'(tk);
      if (tk && model[e] < 3) model[e]++;
      if (!tk && model[e] > 0) model[e]--;
    end else begin
      exp_mis = 0; exp_stall = 0; exp_jmp = 0; // R8
    end
  endtask

  initial begin
    #(MAX_CYCLES * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state, every entry predicts not-taken, outputs clear
    check("R1 mispredict", int'(mispredict), 0);
    check("R1 jump_mark", int'(jump_mark), 0);
    check("R1 stall", int'(stall_cycles), 0);
    for (int i = 0; i < ENTRIES; i++) begin
      br_pc = PC_W'(i * 2); #0.1;
      check("R1 cold prediction", int'(pred_taken), 0);
    end

    // R5: train up and saturate, R9 back-to-back on one entry
    for (int i = 0; i < 5; i++) step("R5 taken train", 1'b1, 32'h0000_1004, 1'b1);
    step("R9 back-to-back lookup", 1'b0, 32'h0000_1004, 1'b0);
    // R6: one not-taken only drops from 3 to 2, still predicts taken
    step("R6 decrement", 1'b1, 32'h0000_1004, 1'b0);
    step("R6 still taken", 1'b1, 32'h0000_1004, 1'b0);
    for (int i = 0; i < 4; i++) step("R6 floor", 1'b1, 32'h0000_1004, 1'b0);

    // R2: aliases share one entry (bit 0 and upper bits ignored)
    step("R2 train", 1'b1, 32'h0000_0010, 1'b1);
    step("R2 train", 1'b1, 32'h0000_0011, 1'b1);
    step("R2 alias bit0", 1'b0, 32'h0000_0011, 1'b0);
    step("R2 alias upper", 1'b0, 32'hABCD_0050, 1'b0);
    step("R2 neighbour untouched", 1'b0, 32'h0000_0012, 1'b0);

    // R8: invalid cycles with taken asserted must not train
    for (int i = 0; i < 4; i++) step("R8 idle no train", 1'b0, 32'h0000_0020, 1'b1);
    step("R8 idle observe", 1'b0, 32'h0000_0020, 1'b0);

    // R3 / R4 / R7: mixed stream across entries
    for (int i = 0; i < 2000; i++) begin
      logic [PC_W-1:0] pc;
      pc = PC_W'($urandom);
      pc[31:8] = '0;
      step("R3 prediction", 1'($urandom % 4 != 0), pc, 1'($urandom % 3 != 0));
    end

    // R1: reset mid-stream clears trained state
    for (int i = 0; i < 3; i++) step("R1 pre-reset train", 1'b1, 32'h0000_0030, 1'b1);
    @(negedge clk);
    br_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < ENTRIES; i++) model[i] = 0;
    exp_mis = 0; exp_jmp = 0; exp_stall = 0;
    step("R1 after reset", 1'b1, 32'h0000_0030, 1'b1);
    step("R1 after reset", 1'b0, 32'h0000_0030, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule